// File: doc/BRIEF.md
# Table-Driven Saturating Angle Counter Pair

This block holds two independent angle counters, each a 9-bit value that stays within 0 to 359 degrees. Neither counter has an adder. Each next count is read from a synchronous lookup table that is filled when the design elaborates. The table address is the count direction placed above the present count. The registered read data is the count itself, and it loops back to form the next address. Saturation at both ends of the range is held in the table contents: the up entry for 359 returns 359, and the down entry for 0 returns 0.

Both counters read from one dual-port table, one port per counter. The read enable of each port is that counter's enable. Its output register has a synchronous reset, and this reset takes priority over the enable. The table is written in a form that maps onto a block RAM with registered outputs, and it replaces the arithmetic and comparison logic of two saturating counters.

Top module: `angle_dual_counter`

## Requirements
- R1: Each angle output stays within 0 to 359 at every clock.
- R2: With reset low, enable high and up high (direction bit 1 in the table address, bit 9), a count below 359 becomes count+1 at the next clock edge.
- R3: With reset low, enable high and up high, a count of 359 stays at 359.
- R4: With reset low, enable high and up low (direction bit 0), a count above 0 becomes count-1 at the next clock edge.
- R5: With reset low, enable high and up low, a count of 0 stays at 0.
- R6: With reset low and enable low, the count keeps its value whatever the up input does.
- R7: Reset high forces the count to 0 at the next clock edge. This holds whether enable is high or low.
- R8: The two counters are independent. The inputs of one port never change the count of the other.
- R9: After power-up both counts read 0 before any reset or enable is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both counters |
| a_en | input | 1 | Counter A enable (table read enable) |
| a_up | input | 1 | Counter A direction, 1 = up, 0 = down |
| a_rst | input | 1 | Counter A synchronous reset, active high |
| a_angle | output | 9 | Counter A angle |
| b_en | input | 1 | Counter B enable (table read enable) |
| b_up | input | 1 | Counter B direction, 1 = up, 0 = down |
| b_rst | input | 1 | Counter B synchronous reset, active high |
| b_angle | output | 9 | Counter B angle |

## Verification
There is a single register between the inputs and each angle, namely the table's output register. Every result, whether a step, a hold, a saturation or a reset, is therefore due on the first rising edge after the inputs are driven. The driver changes the inputs on the falling edge. At that same point it pushes the expected angles, computed by a separate saturating model, into a queue. The monitor takes one entry from the queue 2 ns after each rising edge and compares it with both outputs. Each comparison thus falls inside the cycle whose edge produced the value, before the inputs change again.

// File: rtl/angle_tbl_pkg.sv
package angle_tbl_pkg;

  localparam int unsigned ANGLE_W_DEF   = 9;
  localparam int unsigned ANGLE_MAX_DEF = 359;

  // Next-state entry for one table address.
  // Address layout: [cnt_w+1] spare (zero), [cnt_w] direction, [cnt_w-1:0] count.
  function automatic int unsigned next_entry(int unsigned addr,
                                             int unsigned cnt_w,
                                             int unsigned max_val);
    int unsigned cnt;
    int unsigned dir;
    int unsigned spare;
    cnt   = addr & ((32'd1 << cnt_w) - 32'd1);
    dir   = (addr >> cnt_w) & 32'd1;
    spare = addr >> (cnt_w + 1);
    if (spare != 0 || cnt > max_val) begin
      return 0;
    end
    if (dir == 1) begin
      return (cnt == max_val) ? max_val : cnt + 1;
    end
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

endpackage

// File: rtl/angle_addr_map.sv
module angle_addr_map #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             up,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W+1:0] addr
);
  // Spare top bit tied low; direction selects the table half.
  always_comb begin
    addr = {1'b0, up, count};
  end
endmodule

// File: rtl/angle_tbl_rom.sv
module angle_tbl_rom #(
  parameter int unsigned CNT_W   = angle_tbl_pkg::ANGLE_W_DEF,
  parameter int unsigned MAX_VAL = angle_tbl_pkg::ANGLE_MAX_DEF,
  parameter int unsigned PORTS   = 2
) (
  input  logic                              clk,
  input  logic [PORTS-1:0]                  en,
  input  logic [PORTS-1:0]                  rst,
  input  logic [PORTS-1:0][CNT_W+1:0]       addr,
  output logic [PORTS-1:0][CNT_W-1:0]       q
);
  localparam int unsigned ADDR_W = CNT_W + 2;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] MAX_Q = CNT_W'(MAX_VAL);

  logic [CNT_W-1:0] table_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      table_mem[i] = CNT_W'(angle_tbl_pkg::next_entry(i, CNT_W, MAX_VAL));
    end
  end

  logic past_ok = 1'b0;
  always_ff @(posedge clk) begin
    past_ok <= 1'b1;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [CNT_W-1:0] q_r = '0;

    // Registered read: reset over enable, as on a block RAM output register.
    always_ff @(posedge clk) begin
      if (rst[p]) begin
        q_r <= '0;
      end else if (en[p]) begin
        q_r <= table_mem[addr[p]];
      end
    end

    assign q[p] = q_r;

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!past_ok)
      q[p] <= MAX_Q);                                                          // R1
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!past_ok)
      ($past(en[p]) && !$past(rst[p]) && $past(addr[p][CNT_W]) && ($past(q[p]) != MAX_Q))
      |-> (q[p] == $past(q[p]) + 1'b1));                                       // R2
    AST_UP_HOLD_TOP: assert property (@(posedge clk) disable iff (!past_ok)
      ($past(en[p]) && !$past(rst[p]) && $past(addr[p][CNT_W]) && ($past(q[p]) == MAX_Q))
      |-> (q[p] == MAX_Q));                                                    // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!past_ok)
      ($past(en[p]) && !$past(rst[p]) && !$past(addr[p][CNT_W]) && ($past(q[p]) != '0))
      |-> (q[p] == $past(q[p]) - 1'b1));                                       // R4
    AST_DOWN_HOLD_ZERO: assert property (@(posedge clk) disable iff (!past_ok)
      ($past(en[p]) && !$past(rst[p]) && !$past(addr[p][CNT_W]) && ($past(q[p]) == '0))
      |-> (q[p] == '0));                                                       // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!past_ok)
      (!$past(en[p]) && !$past(rst[p])) |-> $stable(q[p]));                    // R6
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!past_ok)
      $past(rst[p]) |-> (q[p] == '0));                                         // R7
  end
endmodule

// File: rtl/angle_dual_counter.sv
module angle_dual_counter #(
  parameter int unsigned CNT_W     = angle_tbl_pkg::ANGLE_W_DEF,
  parameter int unsigned ANGLE_MAX = angle_tbl_pkg::ANGLE_MAX_DEF
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_up,
  input  logic             a_rst,
  output logic [CNT_W-1:0] a_angle,
  input  logic             b_en,
  input  logic             b_up,
  input  logic             b_rst,
  output logic [CNT_W-1:0] b_angle
);
  localparam int unsigned PORTS  = 2;
  localparam int unsigned ADDR_W = CNT_W + 2;

  logic [PORTS-1:0]              en_v;
  logic [PORTS-1:0]              up_v;
  logic [PORTS-1:0]              rst_v;
  logic [PORTS-1:0][ADDR_W-1:0]  addr_v;
  logic [PORTS-1:0][CNT_W-1:0]   cnt_v;

  assign en_v  = {b_en,  a_en};
  assign up_v  = {b_up,  a_up};
  assign rst_v = {b_rst, a_rst};

  for (genvar p = 0; p < PORTS; p++) begin : g_addr
    angle_addr_map #(.CNT_W(CNT_W)) u_map (
      .up    (up_v[p]),
      .count (cnt_v[p]),
      .addr  (addr_v[p])
    );
  end

  angle_tbl_rom #(
    .CNT_W   (CNT_W),
    .MAX_VAL (ANGLE_MAX),
    .PORTS   (PORTS)
  ) u_tbl (
    .clk  (clk),
    .en   (en_v),
    .rst  (rst_v),
    .addr (addr_v),
    .q    (cnt_v)
  );

  assign a_angle = cnt_v[0];
  assign b_angle = cnt_v[1];
endmodule

// File: tb/angle_dual_counter_bench.sv
module angle_dual_counter_bench;
  localparam int MAXA = 359;

  logic clk = 1'b0;
  logic a_en = 1'b0, a_up = 1'b0, a_rst = 1'b0;
  logic b_en = 1'b0, b_up = 1'b0, b_rst = 1'b0;
  logic [8:0] a_angle, b_angle;

  int errors = 0;
  int checks = 0;
  int ma = 0;
  int mb = 0;
  bit done = 1'b0;

  int    exp_a[$];
  int    exp_b[$];
  string tag_a[$];
  string tag_b[$];

  always #4 clk = ~clk;

  angle_dual_counter u_angle_dual_counter (
    .clk(clk), .a_en(a_en), .a_up(a_up), .a_rst(a_rst), .a_angle(a_angle),
    .b_en(b_en), .b_up(b_up), .b_rst(b_rst), .b_angle(b_angle)
  );

  function automatic int model(bit rst, bit en, bit up, int cur);
    if (rst) return 0;
    if (!en) return cur;
    if (up) return (cur == MAXA) ? MAXA : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  function automatic string tag_of(bit rst, bit en, bit up, int cur);
    if (rst) return "R7";
    if (!en) return "R6";
    if (up) return (cur == MAXA) ? "R3" : "R2";
    return (cur == 0) ? "R5" : "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: new inputs at the falling edge, expected result queued for the next rising edge.
  task automatic drive(bit ea, bit ua, bit ra, bit eb, bit ub, bit rb);
    @(negedge clk);
    a_en = ea; a_up = ua; a_rst = ra;
    b_en = eb; b_up = ub; b_rst = rb;
    tag_a.push_back(tag_of(ra, ea, ua, ma));
    tag_b.push_back({tag_of(rb, eb, ub, mb), "/R8"});
    ma = model(ra, ea, ua, ma);
    mb = model(rb, eb, ub, mb);
    exp_a.push_back(ma);
    exp_b.push_back(mb);
  endtask

  // Monitor: compare 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_a.size() > 0) begin
      check(tag_a.pop_front(), int'(a_angle), exp_a.pop_front());
      check(tag_b.pop_front(), int'(b_angle), exp_b.pop_front());
      check("R1", int'(a_angle > 9'd359), 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2;
    check("R9", int'(a_angle), 0);
    check("R9", int'(b_angle), 0);
    repeat (3) drive(0, 1, 0, 0, 0, 0);            // R6 idle holds zero

    // R2/R3: A sweeps up past the top; R5/R8: B pushes down at zero
    repeat (365) drive(1, 1, 0, 1, 0, 0);
    // R6: enable low, direction toggling
    for (int i = 0; i < 6; i++) drive(0, i[0], 0, 0, i[1], 0);
    // R4: A sweeps down to zero and beyond, B sweeps up (R8)
    repeat (364) drive(1, 0, 0, 1, 1, 0);
    // R7: reset with enable low on B (B at 359), then with enable high on A
    drive(0, 1, 0, 0, 1, 1);
    repeat (20) drive(1, 1, 0, 1, 1, 0);
    drive(1, 1, 1, 0, 0, 0);
    drive(1, 1, 1, 1, 1, 1);

    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 63) == 0,
            $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, $urandom_range(0, 63) == 0);
    end
    drive(0, 0, 0, 0, 0, 0);
    while (exp_a.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule